// File: doc/BRIEF.md
# Selectable Hardware/Software Clock Gate Controller

This block decides whether a downstream clock runs. It produces a registered clock-enable for a clock cell that sits outside the block. Software reaches it through a single 32-bit control word on a plain write-strobe register bus, and the word is always visible on the read-data output. The control word has three fields. A mode field hands the gate either to a hardware auto-gating request, such as the consumer's busy or not-idle signal, or to a software enable field. A read-only state field shows the gate's settled condition.

The state field lags the effective enable by two clock cycles, which models the synchronisation delay in a real gate. After a mode or enable write, software keeps reading until the state field matches what it asked for. A build-time parameter selects the gate variant:

- the full selectable gate;
- a variant that is held open whenever software owns it;
- a variant driven only by the hardware request;
- a "no gate" variant whose clock never stops.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After synchronous reset, the selectable and held-open variants are in software mode with the enable field set, so the control word reads 0x103. The hardware-only and no-gate variants read 0x100. Every variant drives `clk_en_o` high.
- R2: The control word places the enable field at bit 0, the mode field at bit 1 (1 means software owns the gate, 0 means hardware auto-gating) and the read-only state at bit 8. Writes to every other bit and to bit 8 are ignored, and those other bits read 0.
- R3: In software mode the selectable gate drives `clk_en_o` equal to the enable field. The new value appears on the first clock edge after the write is captured.
- R4: In hardware mode the selectable and held-open variants drive `clk_en_o` equal to `hw_req` one clock later, and the enable field has no effect.
- R5: The state bit equals the effective enable delayed by two clock cycles, which is exactly one cycle behind `clk_en_o`.
- R6: A write can move the gate between software and hardware mode at any time. The new mode governs the enable from the cycle after the write.
- R7: The held-open variant keeps `clk_en_o` high whenever the mode field is 1, whatever the enable field holds.
- R8: The hardware-only variant ignores writes, reads its enable and mode fields as 0, and drives `clk_en_o` equal to `hw_req` one cycle later.
- R9: The no-gate variant keeps `clk_en_o` and the state bit at 1, ignores writes, and reads its enable and mode fields as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Write data for the control word |
| bus_rdata | output | 32 | Current control word, including the state bit |
| hw_req | input | 1 | Auto-gating request; 1 asks for the clock to run |
| clk_en_o | output | 1 | Registered clock-enable for the external gate cell |

## Verification
The bench runs one instance of every variant side by side from the same stimulus. It goes after the cycles just after a mode switch: a gate that held the old mode for an extra cycle, or let the enable field leak into hardware mode, would show the wrong `clk_en_o` there. The bench writes all-ones patterns into the unimplemented bits and into the state bit. A decoder that stored those bits, or let software force the state bit, would read back non-zero or wrong data. The bench samples the state bit in each of the two cycles after a change, so a synchroniser one stage too short or too long shows up. It also disables the held-open variant in software mode, where a variant wired like the selectable gate would stop the clock.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;
  localparam int CSR_W       = 32;
  localparam int EN_BIT      = 0;
  localparam int SEL_BIT     = 1;
  localparam int STAT_BIT    = 8;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    CG_NONE     = 2'd0,
    CG_HWSW     = 2'd1,
    CG_HW_OR_ON = 2'd2,
    CG_HW_ONLY  = 2'd3
  } cg_kind_e;

  function automatic bit kind_has_ctrl(cg_kind_e k);
    return (k == CG_HWSW) || (k == CG_HW_OR_ON);
  endfunction
endpackage

// File: rtl/cg_ctrl_reg.sv
`timescale 1ns/1ps
module cg_ctrl_reg #(
  parameter cg_pkg::cg_kind_e KIND = cg_pkg::CG_HWSW
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_en_bit,
  input  logic wr_sel_bit,
  output logic en_q,
  output logic sel_q
);
  generate
    if (cg_pkg::kind_has_ctrl(KIND)) begin : g_store
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q  <= 1'b1;
          sel_q <= 1'b1;
        end else if (wr) begin
          en_q  <= wr_en_bit;
          sel_q <= wr_sel_bit;
        end
      end
    end else begin : g_nostore
      logic unused_wr_bits;
      assign unused_wr_bits = wr ^ wr_en_bit ^ wr_sel_bit ^ clk ^ rst;
      assign en_q  = 1'b0;
      assign sel_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cg_gate_policy.sv
`timescale 1ns/1ps
module cg_gate_policy #(
  parameter cg_pkg::cg_kind_e KIND = cg_pkg::CG_HWSW
) (
  input  logic clk,
  input  logic rst,
  input  logic en_q,
  input  logic sel_q,
  input  logic hw_req,
  output logic eff_en,
  output logic ce_q
);
  generate
    if (KIND == cg_pkg::CG_HWSW) begin : g_hwsw
      assign eff_en = sel_q ? en_q : hw_req;
      // R3
      sw_follow_chk: assert property (@(posedge clk) disable iff (rst)
        sel_q |=> (ce_q == $past(en_q)));
      // R4
      hw_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_q |=> (ce_q == $past(hw_req)));
    end else if (KIND == cg_pkg::CG_HW_OR_ON) begin : g_hw_or_on
      logic unused_en;
      assign unused_en = en_q;
      assign eff_en = sel_q | hw_req;
      // R7
      sw_forced_on_chk: assert property (@(posedge clk) disable iff (rst)
        sel_q |=> ce_q);
      // R4
      hw_follow_on_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_q |=> (ce_q == $past(hw_req)));
    end else if (KIND == cg_pkg::CG_HW_ONLY) begin : g_hw_only
      logic unused_ctl;
      assign unused_ctl = en_q ^ sel_q;
      assign eff_en = hw_req;
      // R8
      hw_only_on_chk: assert property (@(posedge clk) disable iff (rst)
        hw_req |=> ce_q);
      // R8
      hw_only_off_chk: assert property (@(posedge clk) disable iff (rst)
        !hw_req |=> !ce_q);
    end else begin : g_none
      logic unused_all;
      assign unused_all = en_q ^ sel_q ^ hw_req;
      assign eff_en = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ce_q <= 1'b1;
    else     ce_q <= eff_en;
  end
endmodule

// File: rtl/cg_status_sync.sv
`timescale 1ns/1ps
module cg_status_sync #(
  parameter int STAGES = cg_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/clk_gate_ctrl.sv
`timescale 1ns/1ps
module clk_gate_ctrl #(
  parameter cg_pkg::cg_kind_e KIND = cg_pkg::CG_HWSW,
  parameter int CSR_W = cg_pkg::CSR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [CSR_W-1:0] bus_wdata,
  output logic [CSR_W-1:0] bus_rdata,
  input  logic             hw_req,
  output logic             clk_en_o
);
  localparam int EN_B   = cg_pkg::EN_BIT;
  localparam int SEL_B  = cg_pkg::SEL_BIT;
  localparam int STAT_B = cg_pkg::STAT_BIT;

  logic en_q, sel_q, eff_en, stat_q;
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  cg_ctrl_reg #(.KIND(KIND)) u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_wr),
    .wr_en_bit(bus_wdata[EN_B]), .wr_sel_bit(bus_wdata[SEL_B]),
    .en_q(en_q), .sel_q(sel_q)
  );

  cg_gate_policy #(.KIND(KIND)) u_policy (
    .clk(clk), .rst(rst), .en_q(en_q), .sel_q(sel_q),
    .hw_req(hw_req), .eff_en(eff_en), .ce_q(clk_en_o)
  );

  cg_status_sync #(.STAGES(cg_pkg::SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(eff_en), .dout(stat_q)
  );

  always_comb begin
    bus_rdata         = '0;
    bus_rdata[EN_B]   = en_q;
    bus_rdata[SEL_B]  = sel_q;
    bus_rdata[STAT_B] = stat_q;
  end

  generate
    if (cg_pkg::SYNC_STAGES == 2) begin : g_lag_chk
      // R5
      stat_rise_lag_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en_o |=> bus_rdata[STAT_B]);
      // R5
      stat_fall_lag_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en_o |=> !bus_rdata[STAT_B]);
    end
  endgenerate
endmodule

// File: tb/clk_gate_ctrl_tb.sv
`timescale 1ns/1ps
module clk_gate_ctrl_tb;
  localparam int NK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic hw_req = 1'b1;
  logic [NK-1:0] ce_w;
  logic [31:0] rd_w [NK];

  always #2.5 clk = ~clk;

  // index 0 selectable, 1 held-open, 2 hardware-only, 3 no gate
  clk_gate_ctrl #(.KIND(cg_pkg::CG_HWSW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_w[0]), .hw_req(hw_req), .clk_en_o(ce_w[0]));
  clk_gate_ctrl #(.KIND(cg_pkg::CG_HW_OR_ON)) u_dut_forced (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_w[1]), .hw_req(hw_req), .clk_en_o(ce_w[1]));
  clk_gate_ctrl #(.KIND(cg_pkg::CG_HW_ONLY)) u_dut_hwonly (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_w[2]), .hw_req(hw_req), .clk_en_o(ce_w[2]));
  clk_gate_ctrl #(.KIND(cg_pkg::CG_NONE)) u_dut_nogate (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_w[3]), .hw_req(hw_req), .clk_en_o(ce_w[3]));

  typedef struct {
    logic [NK-1:0]       ce;
    logic [NK-1:0][31:0] rd;
    string               tag;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic m_en [NK];
  logic m_sel[NK];
  logic m_ce [NK];
  logic m_s1 [NK];
  logic m_s2 [NK];

  function automatic logic model_eff(int k, logic req);
    case (k)
      0:       return m_sel[k] ? m_en[k] : req;
      1:       return m_sel[k] ? 1'b1 : req;
      2:       return req;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] model_rd(int k);
    logic [31:0] v = '0;
    v[0] = m_en[k];
    v[1] = m_sel[k];
    v[8] = m_s2[k];
    return v;
  endfunction

  task automatic check(string tag, int k, logic ce_a, logic ce_e,
                       logic [31:0] rd_a, logic [31:0] rd_e);
    n_chk++;
    if (ce_a !== ce_e || rd_a !== rd_e) begin
      n_fail++;
      $display("FAIL %s inst%0d clk_en=%b exp %b rdata=%h exp %h",
               tag, k, ce_a, ce_e, rd_a, rd_e);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the post-edge expectation
  task automatic step(string tag, logic wr, logic [31:0] wd, logic req);
    exp_t e;
    @(negedge clk);
    bus_wr = wr;
    bus_wdata = wd;
    hw_req = req;
    for (int k = 0; k < NK; k++) begin
      logic ef;
      ef = model_eff(k, req);
      m_s2[k] = m_s1[k];
      m_s1[k] = ef;
      m_ce[k] = ef;
      if (wr && k < 2) begin
        m_en[k]  = wd[0];
        m_sel[k] = wd[1];
      end
      e.ce[k] = m_ce[k];
      e.rd[k] = model_rd(k);
    end
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare after every edge that has a pending expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        for (int k = 0; k < NK; k++)
          check(e.tag, k, ce_w[k], e.ce[k], rd_w[k], e.rd[k]);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NK; k++) begin
      m_en[k]  = (k < 2);
      m_sel[k] = (k < 2);
      m_ce[k]  = 1'b1;
      m_s1[k]  = 1'b1;
      m_s2[k]  = 1'b1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state before the first active edge
    for (int k = 0; k < NK; k++)
      check("R1 reset", k, ce_w[k], 1'b1, rd_w[k], (k < 2) ? 32'h103 : 32'h100);

    step("R1 R9 idle", 1'b0, 32'h0, 1'b1);
    step("R3 R7 sw disable", 1'b1, 32'h2, 1'b1);
    step("R5 lag 1", 1'b0, 32'h0, 1'b1);
    step("R5 lag 2", 1'b0, 32'h0, 1'b1);
    step("R3 sw enable", 1'b1, 32'h3, 1'b1);
    step("R5 lag rise", 1'b0, 32'h0, 1'b1);
    step("R5 lag rise 2", 1'b0, 32'h0, 1'b1);
    step("R2 junk bits", 1'b1, 32'hFFFF_FEFE, 1'b1);
    step("R2 junk hold", 1'b0, 32'h0, 1'b1);
    step("R2 R5 junk lag", 1'b0, 32'h0, 1'b1);
    step("R6 to hw mode", 1'b1, 32'h0, 1'b0);
    step("R4 R8 req low", 1'b0, 32'h0, 1'b0);
    step("R4 R8 req high", 1'b0, 32'h0, 1'b1);
    step("R4 R8 req low", 1'b0, 32'h0, 1'b0);
    step("R4 R8 req high", 1'b0, 32'h0, 1'b1);
    step("R4 en ignored", 1'b1, 32'h1, 1'b0);
    step("R4 en ignored 2", 1'b0, 32'h0, 1'b0);
    step("R4 R5 en ignored 3", 1'b0, 32'h0, 1'b0);
    step("R6 R7 to sw off", 1'b1, 32'h2, 1'b0);
    step("R7 R8 held open", 1'b0, 32'h0, 1'b0);
    step("R7 R9 held open 2", 1'b0, 32'h0, 1'b1);
    step("R6 to hw on", 1'b1, 32'h1, 1'b1);
    step("R6 hw req drop", 1'b0, 32'h0, 1'b0);
    step("R6 back to sw on", 1'b1, 32'h3, 1'b0);
    step("R3 R9 settle", 1'b0, 32'h0, 1'b0);
    step("R5 settle 2", 1'b0, 32'h0, 1'b0);

    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule